// File: doc/BRIEF.md
# Receive Frame Scatter Engine

The block takes a received frame as a byte stream, one byte per clock on a valid/ready handshake, and spreads it across a linear list of receive descriptors. Each descriptor names a buffer start address and a buffer capacity in bytes. Every accepted byte becomes one byte-write command at the buffer address plus its offset. When a buffer is closed, the block issues a status write-back for its descriptor. The write-back clears the ownership (valid) bit, records the number of bytes stored, and marks the buffer's position in the frame. A frame begins with the first byte after reset or after the previous frame's end marker, and `in_eof_i` flags its last byte.

Descriptors are read through a request/acknowledge fetch port. They are laid out at a fixed stride that a 2-bit size code selects, so the block steps its own descriptor pointer. A small frame fits in one buffer. A larger frame fills each buffer to capacity and moves on to the next descriptor, and the last buffer holds the remainder. Before closing a full buffer, the block fetches the next descriptor. If that descriptor is not owned by the hardware, the block closes the frame with an error, raises an overflow pulse and discards the remaining bytes. It then waits on that descriptor until software hands it over.

Top module: `rx_frame_scatter`

## Requirements
- R1: While reset is held, `in_ready_o`, `wr_en_o`, `wb_en_o` and `ovf_o` are 0. After reset, the first fetch request targets the ring base address (parameter, default 0x1000).
- R2: `dsc_req_o` stays high with a stable `dsc_addr_o` until `dsc_ack_i`, and `in_ready_o` is never high while a fetch is pending. A descriptor returned with `dsc_valid_i`=0 is requested again at the same address until it comes back valid.
- R3: Each accepted byte yields exactly one write command, one cycle after acceptance, at buffer start plus the byte's offset within that buffer, carrying that byte.
- R4: A buffer is filled up to its capacity, the following bytes go to the next descriptor's buffer in list order, and the final buffer receives the remainder.
- R5: Descriptor addresses advance by a stride set by `dl_mode_i`: code 00 gives 16 bytes, 01 gives 32, and 10 or 11 give 64.
- R6: Each used descriptor is written back exactly once, as a single-cycle `wb_en_o` pulse at that descriptor's address. `wb_w0_o` bit 31 (valid) is 0 and `wb_len_o` equals the bytes stored in that buffer.
- R7: The frame position sits in `wb_w0_o` bit 29 (start) and bit 28 (end): 11 for a frame held in one buffer, 10 for the first buffer, 00 for a middle buffer and 01 for the last. All other bits of `wb_w0_o` except bit 30 are 0.
- R8: A frame that ends exactly at a buffer's capacity is closed as the end without consuming a further descriptor, and the next frame starts in the following descriptor.
- R9: If the next descriptor is invalid while frame bytes remain, `ovf_o` pulses with the write-back, and the current descriptor is closed with position end and error bit 30 set. The rest of the frame is accepted and produces no writes, and the next frame goes to the invalid descriptor once it turns valid.
- R10: The error bit 30 is set only on a write-back that also carries the end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dl_mode_i | input | 2 | Descriptor size code selecting the stride |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_eof_i | input | 1 | Marks the last byte of the frame |
| in_ready_o | output | 1 | Byte accepted when high together with valid |
| dsc_req_o | output | 1 | Descriptor fetch request |
| dsc_addr_o | output | AW | Address of the requested descriptor |
| dsc_ack_i | input | 1 | Fetch response present |
| dsc_valid_i | input | 1 | Fetched descriptor is owned by the hardware |
| dsc_cap_i | input | LW | Fetched buffer capacity in bytes (nonzero) |
| dsc_buf_i | input | AW | Fetched buffer start address |
| wr_en_o | output | 1 | Byte write command |
| wr_addr_o | output | AW | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| wb_en_o | output | 1 | Descriptor write-back command |
| wb_addr_o | output | AW | Address of the descriptor written back |
| wb_w0_o | output | 32 | Status word: valid, error, start, end in bits 31..28 |
| wb_len_o | output | LW | Bytes stored in the buffer |
| ovf_o | output | 1 | Overflow pulse: no descriptor for remaining bytes |

## Verification
The bench places a frame end exactly on a buffer boundary. A design that fetched ahead too eagerly would consume a spare descriptor there, and the next frame would land one stride too far. A multi-buffer frame is sent with a capacity that does not divide its length. This exposes remainder lengths that are off by one and position codes that put start or end on the wrong buffer. The overflow case makes the second descriptor invalid in the middle of a frame. A wrong design would keep writing into the closed buffer, leave the error or end flag off, or stall the input instead of discarding it. The bench also recovers once that descriptor turns valid. Each stride code is used in at least one scenario, so a wrong stride shows up as fetches at addresses the descriptor table does not hold.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    ST_FETCH,
    ST_RECV,
    ST_NEXT,
    ST_WB,
    ST_DROP
  } rxs_state_e;

  localparam int W0_VALID = 31;
  localparam int W0_ERR   = 30;
  localparam int W0_SOF   = 29;
  localparam int W0_EOF   = 28;
endpackage

// File: rtl/rxs_dsc_ptr.sv
module rxs_dsc_ptr #(
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter int            UNIT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    dl_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] stride;

  always_comb begin
    unique case (dl_i)
      2'b00:   stride = AW'(UNIT);
      2'b01:   stride = AW'(2 * UNIT);
      default: stride = AW'(4 * UNIT);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= BASE;
    else if (adv_i) ptr_q <= ptr_q + stride;
  end

  assign cur_o = ptr_q;
  assign nxt_o = ptr_q + stride;
endmodule

// File: rtl/rxs_buf_track.sv
module rxs_buf_track #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] cap_i,
  input  logic [AW-1:0] buf_i,
  input  logic          take_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] cnt_o,
  output logic          last_o
);
  logic [AW-1:0] buf_q;
  logic [LW-1:0] cap_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cap_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      buf_q <= buf_i;
      cap_q <= cap_i;
      cnt_q <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign addr_o = buf_q + AW'(cnt_q);
  assign cnt_o  = cnt_q;
  // byte being taken now is the last that fits
  assign last_o = (cnt_q + 1'b1) == cap_q;
endmodule

// File: rtl/rx_frame_scatter.sv
module rx_frame_scatter
  import rxs_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            LW        = 16,
  parameter int            UNIT      = 16,
  parameter logic [AW-1:0] RING_BASE = AW'(32'h1000)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    dl_mode_i,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  input  logic          in_eof_i,
  output logic          in_ready_o,
  output logic          dsc_req_o,
  output logic [AW-1:0] dsc_addr_o,
  input  logic          dsc_ack_i,
  input  logic          dsc_valid_i,
  input  logic [LW-1:0] dsc_cap_i,
  input  logic [AW-1:0] dsc_buf_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [31:0]   wb_w0_o,
  output logic [LW-1:0] wb_len_o,
  output logic          ovf_o
);
  rxs_state_e st_q, ret_q;
  logic first_q;
  logic accept, take, load, adv;
  logic [AW-1:0] cur_ptr, nxt_ptr, buf_addr;
  logic [LW-1:0] cnt;
  logic last;

  assign in_ready_o = (st_q == ST_RECV) || (st_q == ST_DROP);
  assign dsc_req_o  = (st_q == ST_FETCH) || (st_q == ST_NEXT);
  assign dsc_addr_o = (st_q == ST_NEXT) ? nxt_ptr : cur_ptr;

  assign accept = in_valid_i && in_ready_o;
  assign take   = accept && (st_q == ST_RECV);
  assign load   = dsc_req_o && dsc_ack_i && dsc_valid_i;
  assign adv    = (take && in_eof_i) || ((st_q == ST_NEXT) && dsc_ack_i);

  rxs_dsc_ptr #(.AW(AW), .BASE(RING_BASE), .UNIT(UNIT)) i_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dl_i  (dl_mode_i),
    .adv_i (adv),
    .cur_o (cur_ptr),
    .nxt_o (nxt_ptr)
  );

  rxs_buf_track #(.AW(AW), .LW(LW)) i_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cap_i (dsc_cap_i),
    .buf_i (dsc_buf_i),
    .take_i(take),
    .addr_o(buf_addr),
    .cnt_o (cnt),
    .last_o(last)
  );

  // byte write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= take;
      if (take) begin
        wr_addr_o <= buf_addr;
        wr_data_o <= in_data_i;
      end
    end
  end

  // control and write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_FETCH;
      ret_q     <= ST_FETCH;
      first_q   <= 1'b1;
      wb_en_o   <= 1'b0;
      wb_addr_o <= '0;
      wb_w0_o   <= '0;
      wb_len_o  <= '0;
      ovf_o     <= 1'b0;
    end else begin
      wb_en_o <= 1'b0;
      ovf_o   <= 1'b0;
      unique case (st_q)
        ST_FETCH: if (load) st_q <= ST_RECV;
        ST_RECV: begin
          if (take) begin
            if (in_eof_i) begin
              wb_en_o   <= 1'b1;
              wb_addr_o <= cur_ptr;
              wb_w0_o   <= {1'b0, 1'b0, first_q, 1'b1, 28'b0};
              wb_len_o  <= cnt + 1'b1;
              first_q   <= 1'b1;
              ret_q     <= ST_FETCH;
              st_q      <= ST_WB;
            end else if (last) begin
              st_q <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          if (dsc_ack_i) begin
            wb_en_o   <= 1'b1;
            wb_addr_o <= cur_ptr;
            wb_len_o  <= cnt;
            st_q      <= ST_WB;
            if (dsc_valid_i) begin
              wb_w0_o <= {1'b0, 1'b0, first_q, 1'b0, 28'b0};
              first_q <= 1'b0;
              ret_q   <= ST_RECV;
            end else begin
              // no room left: close with error, drop the tail
              wb_w0_o <= {1'b0, 1'b1, first_q, 1'b1, 28'b0};
              ovf_o   <= 1'b1;
              first_q <= 1'b1;
              ret_q   <= ST_DROP;
            end
          end
        end
        ST_WB:   st_q <= ret_q;
        ST_DROP: if (accept && in_eof_i) st_q <= ST_FETCH;
        default: st_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_scatter_chk.sv
module rx_frame_scatter_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          dsc_req_o,
  input logic [AW-1:0] dsc_addr_o,
  input logic          dsc_ack_i,
  input logic          wr_en_o,
  input logic          wb_en_o,
  input logic [31:0]   wb_w0_o,
  input logic [LW-1:0] wb_len_o,
  input logic          ovf_o
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_req_o && !dsc_ack_i |=> dsc_req_o && $stable(dsc_addr_o));

  p_no_ready_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !dsc_req_o);

  p_wr_after_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(in_valid_i && in_ready_o));

  p_wb_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> !wb_w0_o[31] && (wb_len_o != '0));

  p_wb_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> !wb_en_o);

  p_ovf_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> wb_en_o && wb_w0_o[30] && wb_w0_o[28]);

  p_err_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o && wb_w0_o[30] |-> wb_w0_o[28]);
endmodule

bind rx_frame_scatter rx_frame_scatter_chk #(.AW(AW), .LW(LW)) i_chk (.*);

// File: tb/test_rx_frame_scatter.sv
module test_rx_frame_scatter;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] dl_mode_i = 2'b00;
  logic in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic in_eof_i = 1'b0;
  logic in_ready_o;
  logic dsc_req_o;
  logic [AW-1:0] dsc_addr_o;
  logic dsc_ack_i = 1'b0;
  logic dsc_valid_i = 1'b0;
  logic [LW-1:0] dsc_cap_i = '0;
  logic [AW-1:0] dsc_buf_i = '0;
  logic wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic wb_en_o;
  logic [AW-1:0] wb_addr_o;
  logic [31:0] wb_w0_o;
  logic [LW-1:0] wb_len_o;
  logic ovf_o;

  always #5 clk_i = ~clk_i;

  rx_frame_scatter i_rx_frame_scatter (.*);

  int n_chk = 0, n_fail = 0;
  logic        t_vld [0:15];
  logic [15:0] t_cap [0:15];
  logic [31:0] t_buf [0:15];
  logic [31:0] wr_a [0:255];
  logic [7:0]  wr_d [0:255];
  logic [31:0] wb_a [0:31];
  logic [31:0] wb_w [0:31];
  logic [15:0] wb_l [0:31];
  int nwr = 0, nwb = 0, novf = 0;

  function automatic int stride_of(input logic [1:0] dl);
    return (dl == 2'b00) ? 16 : (dl == 2'b01) ? 32 : 64;
  endfunction

  // descriptor memory model
  always @(negedge clk_i) begin
    if (rst_ni && dsc_req_o) begin
      automatic int s = stride_of(dl_mode_i);
      automatic logic [31:0] off = dsc_addr_o - BASE;
      automatic int idx = int'(off) / s;
      dsc_ack_i = 1'b1;
      if ((int'(off) % s == 0) && idx >= 0 && idx < 16) begin
        dsc_valid_i = t_vld[idx];
        dsc_cap_i   = t_cap[idx];
        dsc_buf_i   = t_buf[idx];
      end else begin
        dsc_valid_i = 1'b0;
      end
    end else begin
      dsc_ack_i = 1'b0;
    end
  end

  // command log
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wr_en_o && nwr < 256) begin wr_a[nwr] = wr_addr_o; wr_d[nwr] = wr_data_o; nwr++; end
      if (wb_en_o && nwb < 32) begin wb_a[nwb] = wb_addr_o; wb_w[nwb] = wb_w0_o; wb_l[nwb] = wb_len_o; nwb++; end
      if (ovf_o) novf++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] dl);
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    in_eof_i = 1'b0;
    dl_mode_i = dl;
    for (int k = 0; k < 16; k++) begin
      t_vld[k] = 1'b1;
      t_cap[k] = 16'd4;
      t_buf[k] = 32'h8000_0000 + 32'(k) * 32'h100;
    end
    nwr = 0; nwb = 0; novf = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_data_i  = seed + 8'(i);
      in_eof_i   = (i == n - 1);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_eof_i = 1'b0;
    repeat (6) @(negedge clk_i);
  endtask

  // frame bytes must land in consecutive descriptors starting at first_idx
  task automatic chk_data(input string req, input int wr0, input int first_idx,
                          input int cap, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      automatic logic [31:0] ea = t_buf[first_idx + i / cap] + 32'(i % cap);
      if (wr0 + i >= nwr) begin
        chk(req, 32'hdead, 32'(i));
        return;
      end
      chk(req, wr_a[wr0 + i], ea);
      chk(req, 32'(wr_d[wr0 + i]), 32'(seed + 8'(i)));
    end
  endtask

  task automatic chk_wb(input string req, input int k, input logic [31:0] a,
                        input logic [31:0] w, input logic [15:0] l);
    chk(req, wb_a[k], a);
    chk(req, wb_w[k], w);
    chk(req, 32'(wb_l[k]), 32'(l));
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 ready", 32'(in_ready_o), 0);
    chk("R1 wr_en", 32'(wr_en_o), 0);
    chk("R1 wb_en", 32'(wb_en_o), 0);
    chk("R1 ovf", 32'(ovf_o), 0);
    rst_ni = 1'b1;
    #1;
    chk("R1 first req", 32'(dsc_req_o), 1);
    chk("R1 first addr", dsc_addr_o, BASE);
  endtask

  task automatic t_single;
    do_reset(2'b00);
    t_cap[0] = 16'd64;
    send_frame(20, 8'h10);
    chk("R3 write count", 32'(nwr), 20);
    chk_data("R3 data", 0, 0, 64, 20, 8'h10);
    chk("R6 wb count", 32'(nwb), 1);
    chk_wb("R7 single", 0, BASE, 32'h3000_0000, 16'd20);
  endtask

  task automatic t_multi;
    do_reset(2'b01);
    for (int k = 0; k < 4; k++) t_cap[k] = 16'd5;
    send_frame(17, 8'h40);
    chk("R4 write count", 32'(nwr), 17);
    chk_data("R4 scatter", 0, 0, 5, 17, 8'h40);
    chk("R6 wb count", 32'(nwb), 4);
    chk_wb("R7 first R5", 0, BASE, 32'h2000_0000, 16'd5);
    chk_wb("R7 middle R5", 1, BASE + 32, 32'h0000_0000, 16'd5);
    chk_wb("R7 middle R5", 2, BASE + 64, 32'h0000_0000, 16'd5);
    chk_wb("R4 remainder R7", 3, BASE + 96, 32'h1000_0000, 16'd2);
    chk("R9 no ovf", 32'(novf), 0);
  endtask

  task automatic t_exact;
    do_reset(2'b10);
    send_frame(8, 8'h80);
    chk("R8 wb count", 32'(nwb), 2);
    chk_wb("R8 first", 0, BASE, 32'h2000_0000, 16'd4);
    chk_wb("R8 end", 1, BASE + 64, 32'h1000_0000, 16'd4);
    send_frame(3, 8'hA0);
    chk("R8 wb total", 32'(nwb), 3);
    chk_wb("R8 next frame R5", 2, BASE + 128, 32'h3000_0000, 16'd3);
    chk_data("R8 next data", 8, 2, 4, 3, 8'hA0);
  endtask

  task automatic t_overflow;
    do_reset(2'b11);
    t_vld[1] = 1'b0;
    send_frame(10, 8'h20);
    chk("R9 writes stop", 32'(nwr), 4);
    chk_data("R9 kept data", 0, 0, 4, 4, 8'h20);
    chk("R9 ovf pulse", 32'(novf), 1);
    chk("R9 wb count", 32'(nwb), 1);
    chk_wb("R9 R10 err end", 0, BASE, 32'h7000_0000, 16'd4);
    t_vld[1] = 1'b1;
    send_frame(2, 8'h60);
    chk("R9 recover wb", 32'(nwb), 2);
    chk_wb("R9 recover R5", 1, BASE + 64, 32'h3000_0000, 16'd2);
    chk_data("R9 recover data", 4, 1, 4, 2, 8'h60);
  endtask

  task automatic t_poll;
    do_reset(2'b00);
    t_vld[0] = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R2 ready low", 32'(in_ready_o), 0);
    chk("R2 polling", 32'(dsc_req_o), 1);
    chk("R2 poll addr", dsc_addr_o, BASE);
    t_vld[0] = 1'b1;
    t_cap[0] = 16'd3;
    send_frame(3, 8'hC0);
    chk("R2 wb after poll", 32'(nwb), 1);
    chk_wb("R2 single", 0, BASE, 32'h3000_0000, 16'd3);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      t_vld[k] = 1'b0; t_cap[k] = '0; t_buf[k] = '0;
    end
    repeat (2) @(negedge clk_i);
    t_reset;
    t_single;
    t_multi;
    t_exact;
    t_overflow;
    t_poll;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule